// File: doc/BRIEF.md
# Hardware Mutex Bank with Read-to-Claim Registers

This block holds a set of single-bit mutex flags that several processors reach through a simple register bus (select, write enable, byte address, write data, read data, at most one access per clock). Software that wants a shared resource reads the register of the matching mutex. When that read returns 0, the mutex was free and the reader now owns it, because the same read marks it taken. When the read returns 1, another agent holds the mutex and nothing changes. The owner gives the mutex back by writing 0 to its register.

A read-only status word at the bottom of the address map reports how many mutexes the bank was built with, as a small code in its top four bits. The count is a build-time parameter (32, 64, 128 or 256). Read data is combinational in the access cycle and reflects the state before that cycle's update, which the register stage commits at the closing clock edge. Every claim and release therefore completes in one cycle, and two processors cannot both win.

Top module: `hwlock_bank`

## Requirements
- R1: A read of byte offset 0x000 returns the status word. Bits [31:28] hold log2(NUM_LOCKS)-4, so 32→1, 64→2, 128→3 and 256→4, and all other bits are 0. With 64 mutexes the value is 0x20000000.
- R2: Mutex i lives at byte offset 0x100 + 4*i, and address bits [1:0] are ignored. A read of a free mutex returns 0x00000000 and marks it taken from the next cycle on.
- R3: A read of a taken mutex returns 0x00000001, and the mutex stays taken.
- R4: Writing 0x00000000 to a mutex register releases that mutex. A following read then returns 0.
- R5: Writing any nonzero value to a mutex register leaves every mutex unchanged.
- R6: Writes to the status word are ignored, and the status word keeps its value.
- R7: Accesses to mutex indices at or above NUM_LOCKS, or to offsets 0x004 through 0x0FC, read as 0 and change no mutex.
- R8: Two back-to-back reads of a free mutex return 0 and then 1.
- R9: Asserting the active-low reset releases every mutex.
- R10: Read data is 0 in any cycle that is not a read (select low, or a write).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel | input | 1 | Access valid in this cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the read cycle |

## Verification
The bench builds the bank with 64 mutexes. At that size the status code is 2 rather than the default 1. The last valid index 63 sits at 0x1FC, and the first index past the end, at 0x200, lies inside the 12-bit address space. The random address mix reaches indices 64 to 79 and the hole below 0x100, so the bounds check and the unmapped range are exercised together with claims and releases that collide on the same mutexes.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;

  localparam int unsigned LOCK_BASE_WORD = 64;
  localparam int unsigned DATA_W         = 32;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_STATUS = 2'd1,
    ACC_LOCK   = 2'd2
  } acc_kind_e;

  function automatic logic [3:0] count_code(input int unsigned n);
    return 4'($clog2(n) - 4);
  endfunction

endpackage

// File: rtl/hwlock_decode.sv
module hwlock_decode
  import hwlock_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned IDX_W     = $clog2(NUM_LOCKS)
) (
  input  logic                  sel,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output acc_kind_e             kind,
  output logic [IDX_W-1:0]      idx,
  output logic [NUM_LOCKS-1:0]  claim_oh,
  output logic [NUM_LOCKS-1:0]  release_oh
);

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] BASE_W  = WORD_W'(LOCK_BASE_WORD);
  localparam logic [WORD_W-1:0] COUNT_W = WORD_W'(NUM_LOCKS);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] offs;
  logic              lock_hit;
  logic              rd_lock;
  logic              wr_zero;
  logic              unused_byte_lane;

  assign word             = addr[ADDR_W-1:2];
  assign unused_byte_lane = ^addr[1:0];
  assign offs             = word - BASE_W;
  assign lock_hit         = (word >= BASE_W) && (offs < COUNT_W);
  assign idx              = offs[IDX_W-1:0];
  assign rd_lock          = sel && !wr_en && lock_hit;
  assign wr_zero          = sel && wr_en && lock_hit && (wdata == '0);

  always_comb begin
    if (word == '0)    kind = ACC_STATUS;
    else if (lock_hit) kind = ACC_LOCK;
    else               kind = ACC_NONE;
  end

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_sel
    assign claim_oh[i]   = rd_lock && (idx == IDX_W'(i));
    assign release_oh[i] = wr_zero && (idx == IDX_W'(i));
  end

endmodule

// File: rtl/hwlock_flags.sv
module hwlock_flags #(
  parameter int unsigned NUM_LOCKS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LOCKS-1:0] claim_oh,
  input  logic [NUM_LOCKS-1:0] release_oh,
  output logic [NUM_LOCKS-1:0] flags_q
);

  logic [NUM_LOCKS-1:0] flags_d;
  logic                 flags_en;

  always_comb begin
    flags_en = |(claim_oh | release_oh);
    flags_d  = (flags_q | claim_oh) & ~release_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank
  import hwlock_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);

  localparam int unsigned IDX_W       = $clog2(NUM_LOCKS);
  localparam logic [31:0] STATUS_WORD = {count_code(NUM_LOCKS), 28'h0};

  acc_kind_e            kind;
  logic [IDX_W-1:0]     idx;
  logic [NUM_LOCKS-1:0] claim_oh;
  logic [NUM_LOCKS-1:0] release_oh;
  logic [NUM_LOCKS-1:0] flags_q;

  hwlock_decode #(
    .NUM_LOCKS (NUM_LOCKS),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W)
  ) u_decode (
    .sel        (sel),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .kind       (kind),
    .idx        (idx),
    .claim_oh   (claim_oh),
    .release_oh (release_oh)
  );

  hwlock_flags #(
    .NUM_LOCKS (NUM_LOCKS)
  ) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .claim_oh   (claim_oh),
    .release_oh (release_oh),
    .flags_q    (flags_q)
  );

  always_comb begin
    rdata = '0;
    if (sel && !wr_en) begin
      unique case (kind)
        ACC_STATUS: rdata = STATUS_WORD;
        ACC_LOCK:   rdata = {31'h0, flags_q[idx]};
        default:    rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/hwlock_bank_chk.sv
module hwlock_bank_chk #(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sel,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [31:0]          wdata,
  input logic [31:0]          rdata,
  input logic [NUM_LOCKS-1:0] flags_q
);

  localparam int unsigned IDX_W  = $clog2(NUM_LOCKS);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [31:0] EXP_STATUS = {4'($clog2(NUM_LOCKS) - 4), 28'h0};

  logic [WORD_W-1:0] c_word;
  logic [WORD_W-1:0] c_offs;
  logic              c_is_lock;
  logic [IDX_W-1:0]  c_idx;
  logic              c_rd;

  assign c_word    = addr[ADDR_W-1:2];
  assign c_offs    = c_word - WORD_W'(64);
  assign c_is_lock = (c_word >= WORD_W'(64)) && (c_offs < WORD_W'(NUM_LOCKS));
  assign c_idx     = c_offs[IDX_W-1:0];
  assign c_rd      = sel && !wr_en;

  p_status_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && c_word == '0) |-> (rdata == EXP_STATUS));

  p_free_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && c_is_lock && !flags_q[c_idx]) |-> (rdata == 32'h0));

  p_claim_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && c_is_lock) |=> flags_q[$past(c_idx)]);

  p_taken_reads_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && c_is_lock && flags_q[c_idx]) |-> (rdata == 32'h1));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && c_is_lock && wdata == 32'h0) |=> !flags_q[$past(c_idx)]);

  p_nonzero_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && wdata != 32'h0) |=> $stable(flags_q));

  p_unmapped_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !c_is_lock) |=> $stable(flags_q));

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && !c_is_lock && c_word != '0) |-> (rdata == 32'h0));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rd |-> (rdata == 32'h0));

endmodule

bind hwlock_bank hwlock_bank_chk #(
  .NUM_LOCKS (NUM_LOCKS),
  .ADDR_W    (ADDR_W)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel     (sel),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .flags_q (flags_q)
);

// File: tb/hwlock_bank_tb_top.sv
module hwlock_bank_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N_LOCKS    = 64;
  localparam int unsigned AW         = 12;

  logic          clk;
  logic          rst_n;
  logic          sel;
  logic          wr_en;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;

  int n_cmp;
  int n_bad;
  bit model_q [N_LOCKS];

  hwlock_bank #(.NUM_LOCKS(N_LOCKS), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit m_is_lock(input logic [AW-1:0] a);
    int w;
    w = int'(a >> 2);
    return (w >= 64) && (w - 64 < N_LOCKS);
  endfunction

  function automatic int m_idx(input logic [AW-1:0] a);
    return int'(a >> 2) - 64;
  endfunction

  function automatic logic [31:0] m_rdata(input logic s, input logic w,
                                          input logic [AW-1:0] a);
    if (!s || w) return 32'h0;
    if ((a >> 2) == 0) return 32'h2000_0000;
    if (m_is_lock(a)) return {31'h0, model_q[m_idx(a)]};
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic bus(input logic s, input logic w, input logic [AW-1:0] a,
                     input logic [31:0] d, input string req);
    logic [31:0] exp;
    @(negedge clk);
    sel = s; wr_en = w; addr = a; wdata = d;
    #(CLK_PERIOD/4);
    exp = m_rdata(s, w, a);
    check(req, rdata, exp);
    if (s && m_is_lock(a)) begin
      if (!w) model_q[m_idx(a)] = 1'b1;
      else if (d == 32'h0) model_q[m_idx(a)] = 1'b0;
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < N_LOCKS; i++) model_q[i] = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    void'($urandom(32'd4711));
    rst_n = 1'b0; sel = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: idle cycle and write cycle read back zero
    bus(1'b0, 1'b0, 12'h100, 32'h0, "R10 idle");
    bus(1'b1, 1'b1, 12'h100, 32'h5, "R10 write cycle");
    // R1: status value for 64 mutexes
    bus(1'b1, 1'b0, 12'h000, 32'h0, "R1 status");
    // R6: write to status ignored
    bus(1'b1, 1'b1, 12'h000, 32'h0, "R6 status write");
    bus(1'b1, 1'b1, 12'h000, 32'hFFFF_FFFF, "R6 status write");
    bus(1'b1, 1'b0, 12'h000, 32'h0, "R6 status after write");
    // R2/R8: back-to-back reads of a free mutex
    bus(1'b1, 1'b0, 12'h104, 32'h0, "R8 first read");
    bus(1'b1, 1'b0, 12'h104, 32'h0, "R8 second read");
    // R3: taken mutex stays taken
    bus(1'b1, 1'b0, 12'h104, 32'h0, "R3 taken read");
    // R5: nonzero write has no effect
    bus(1'b1, 1'b1, 12'h104, 32'h1, "R5 nonzero write");
    bus(1'b1, 1'b0, 12'h104, 32'h0, "R5 still taken");
    // R4: release then claim again
    bus(1'b1, 1'b1, 12'h104, 32'h0, "R4 release");
    bus(1'b1, 1'b0, 12'h104, 32'h0, "R4 free after release");
    // R2: last valid index and ignored low address bits
    bus(1'b1, 1'b0, 12'h1FF, 32'h0, "R2 last index");
    bus(1'b1, 1'b0, 12'h1FC, 32'h0, "R2 last index taken");
    // R7: index past the end and hole below the mutexes
    bus(1'b1, 1'b0, 12'h200, 32'h0, "R7 past end");
    bus(1'b1, 1'b0, 12'h200, 32'h0, "R7 past end again");
    bus(1'b1, 1'b0, 12'h0FC, 32'h0, "R7 hole read");
    bus(1'b1, 1'b1, 12'h0FC, 32'h0, "R7 hole write");
    bus(1'b1, 1'b0, 12'h1FC, 32'h0, "R7 neighbour unchanged");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [AW-1:0] a;
      logic [31:0]   d;
      int unsigned   pick;
      pick = $urandom % 8;
      if (pick == 0)      a = {10'h0, 2'($urandom)};
      else if (pick == 1) a = AW'($urandom);
      else                a = AW'(12'h100 + 4 * ($urandom % 80) + ($urandom % 4));
      d = ($urandom % 2 == 0) ? 32'h0 : (32'($urandom) | 32'h1);
      bus(($urandom % 8) != 0, ($urandom % 2) == 0, a, d, "R2 R3 R4 R5 R7 random");
    end

    // R9: reset releases every mutex
    for (int i = 0; i < 8; i++) bus(1'b1, 1'b0, AW'(12'h100 + 4 * i), 32'h0, "R9 claim");
    @(negedge clk);
    sel = 1'b0; rst_n = 1'b0;
    clear_model();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N_LOCKS; i++)
      bus(1'b1, 1'b0, AW'(12'h100 + 4 * i), 32'h0, "R9 free after reset");

    @(negedge clk);
    sel = 1'b0;
    summary();
    $finish;
  end

endmodule